// File: doc/BRIEF.md
# Operand Effective-Address Generator

This unit sits beside the decoder of an 8-bit processor with a 16-bit address bus. It takes an addressing-mode code, the PC of the first operand byte and the two index registers. It fetches the operand bytes and any page-zero pointer bytes through a synchronous byte-read port. It then returns the 16-bit effective address and the PC that follows the operand bytes, marked by a one-cycle done pulse. Executing the operation is left to other logic.

A request is taken when `start` is high and the unit is idle. The mode, PC and index values are captured on that edge, so the caller may change them afterwards. Every memory read takes two cycles, a request cycle and a capture cycle. The latency therefore depends only on how many bytes the mode needs. Page-zero arithmetic wraps within 8 bits. Only the indirect-then-indexed mode adds its index after the full 16-bit pointer has been assembled.

Top module: `ea_gen`

## Requirements
- R1: Mode codes: 0 = indexed-X indirect through page zero, 1 = page zero, 2 = immediate, 3 = absolute, 4 = page-zero indirect then Y-indexed, 5 = page zero + X, 6 = absolute + Y, 7 = absolute + X, 8 = page zero + Y, 9 = relative. Codes 10 to 15 behave exactly like code 2.
- R2: Immediate mode returns the input PC as the address and PC + 1 (mod 65536) as the next PC. It issues no memory read, and done rises one cycle after the accepting edge.
- R3: Page-zero modes read one byte b at PC. They return {0x00, b}, {0x00, (b + X) mod 256} or {0x00, (b + Y) mod 256}, with next PC = PC + 1.
- R4: Absolute modes read the low byte at PC and the high byte at (PC + 1) mod 65536. The index, if any, is added modulo 65536, and next PC = PC + 2.
- R5: Mode 0 forms location p = (b + X) mod 256. It reads the pointer low byte at {0x00, p} and the high byte at {0x00, (p + 1) mod 256}, and the pointer is the address.
- R6: Mode 4 reads the pointer from {0x00, b} and {0x00, (b + 1) mod 256}. The address is (pointer + Y) mod 65536.
- R7: Relative mode returns (PC + 1 + sign-extended b) mod 65536 and next PC = PC + 1.
- R8: The read port's data is taken on the cycle after `rd_en`. `rd_en` is high exactly once per byte fetched and never while the unit is idle.
- R9: `done` is high for exactly one cycle, 1 + 2n cycles after the accepting edge, where n is 0 (immediate), 1 (page zero, its indexed forms, relative), 2 (absolute forms) or 3 (both indirect forms). `busy` is high from the accepting edge through the done cycle.
- R10: A `start` while `busy` is high is ignored, and the result reflects the inputs captured at acceptance.
- R11: After reset, `busy`, `done` and `rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request; accepted only while idle |
| mode | input | 4 | Addressing-mode code (R1) |
| pc_in | input | 16 | Address of the first operand byte |
| x_in | input | 8 | X index |
| y_in | input | 8 | Y index |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result strobe |
| ea | output | 16 | Effective address, valid with done |
| pc_next | output | 16 | PC after the operand bytes, valid with done |
| rd_en | output | 1 | Byte-read request |
| rd_addr | output | 16 | Byte-read address |
| rd_data | input | 8 | Read data, valid the cycle after rd_en |

## Verification
The assertions assume that the memory port answers every read with data on the following cycle, with no wait states. The bench models memory as a fixed arithmetic function of the address with a selectable salt, and its read process answers one cycle later, so that assumption always holds. The assertions also assume that `rst_n` is held for at least one edge before the first request. The bench holds `start` low during reset and raises intruding requests only while a transaction is in progress.

// File: rtl/ea_pkg.sv
package ea_pkg;

  localparam int WORD_W = 8;
  localparam int ADDR_W = 2 * WORD_W;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    AM_XIND = 4'd0,
    AM_ZP   = 4'd1,
    AM_IMM  = 4'd2,
    AM_ABS  = 4'd3,
    AM_INDY = 4'd4,
    AM_ZPX  = 4'd5,
    AM_ABSY = 4'd6,
    AM_ABSX = 4'd7,
    AM_ZPY  = 4'd8,
    AM_REL  = 4'd9
  } amode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_CAP,
    ST_DONE
  } seq_st_e;

  // Modes that fetch a second operand byte.
  function automatic logic wide_operand(input logic [MODE_W-1:0] m);
    return (m == AM_ABS) || (m == AM_ABSX) || (m == AM_ABSY);
  endfunction

  // Modes that fetch a pointer from page zero.
  function automatic logic uses_pointer(input logic [MODE_W-1:0] m);
    return (m == AM_XIND) || (m == AM_INDY);
  endfunction

  // Any mode apart from immediate (and the reserved codes) reads memory.
  function automatic logic reads_memory(input logic [MODE_W-1:0] m);
    return (m == AM_XIND) || (m == AM_ZP) || (m == AM_ABS) || (m == AM_INDY) ||
           (m == AM_ZPX) || (m == AM_ABSY) || (m == AM_ABSX) || (m == AM_ZPY) ||
           (m == AM_REL);
  endfunction

  // Operand bytes consumed from the instruction stream.
  function automatic logic [1:0] operand_len(input logic [MODE_W-1:0] m);
    return wide_operand(m) ? 2'd2 : 2'd1;
  endfunction

  function automatic logic [ADDR_W-1:0] page0(input logic [WORD_W-1:0] b,
                                              input logic [WORD_W-1:0] idx);
    logic [WORD_W-1:0] s;
    s = b + idx;
    return {{WORD_W{1'b0}}, s};
  endfunction

  function automatic logic [ADDR_W-1:0] index16(input logic [ADDR_W-1:0] base,
                                                input logic [WORD_W-1:0] idx);
    return base + {{(ADDR_W-WORD_W){1'b0}}, idx};
  endfunction

  function automatic logic [ADDR_W-1:0] rel_target(input logic [ADDR_W-1:0] pc_after,
                                                   input logic [WORD_W-1:0] off);
    return pc_after + {{(ADDR_W-WORD_W){off[WORD_W-1]}}, off};
  endfunction

endpackage

// File: rtl/ea_seq.sv
module ea_seq
  import ea_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [WORD_W-1:0] x_in,
  input  logic [WORD_W-1:0] y_in,
  input  logic [WORD_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [MODE_W-1:0] mode_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic [WORD_W-1:0] x_q,
  output logic [WORD_W-1:0] y_q,
  output logic [WORD_W-1:0] op_lo,
  output logic [WORD_W-1:0] op_hi,
  output logic [WORD_W-1:0] ptr_lo,
  output logic [WORD_W-1:0] ptr_hi
);

  seq_st_e           state;
  logic [1:0]        step;       // 0 op low, 1 op high, 2 ptr low, 3 ptr high
  logic [1:0]        step_nxt;
  logic              last_byte;
  logic              accept;
  logic              ptr_phase;
  logic [WORD_W-1:0] ptr_loc;

  assign accept    = (state == ST_IDLE) && start;
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign rd_en     = (state == ST_REQ);
  assign ptr_phase = rd_en && step[1];
  assign ptr_loc   = (mode_q == AM_XIND) ? (op_lo + x_q) : op_lo;

  always_comb begin
    case (step)
      2'd0:    rd_addr = pc_q;
      2'd1:    rd_addr = pc_q + 16'd1;
      2'd2:    rd_addr = page0(ptr_loc, 8'd0);
      default: rd_addr = page0(ptr_loc, 8'd1);
    endcase
  end

  always_comb begin
    step_nxt  = step;
    last_byte = 1'b0;
    case (step)
      2'd0: begin
        if (wide_operand(mode_q))      step_nxt = 2'd1;
        else if (uses_pointer(mode_q)) step_nxt = 2'd2;
        else                           last_byte = 1'b1;
      end
      2'd1:    last_byte = 1'b1;
      2'd2:    step_nxt = 2'd3;
      default: last_byte = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      step   <= 2'd0;
      mode_q <= '0;
      pc_q   <= '0;
      x_q    <= '0;
      y_q    <= '0;
      op_lo  <= '0;
      op_hi  <= '0;
      ptr_lo <= '0;
      ptr_hi <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          mode_q <= mode;
          pc_q   <= pc_in;
          x_q    <= x_in;
          y_q    <= y_in;
          step   <= 2'd0;
          state  <= reads_memory(mode) ? ST_REQ : ST_DONE;
        end
        ST_REQ: state <= ST_CAP;
        ST_CAP: begin
          case (step)
            2'd0:    op_lo  <= rd_data;
            2'd1:    op_hi  <= rd_data;
            2'd2:    ptr_lo <= rd_data;
            default: ptr_hi <= rd_data;
          endcase
          step  <= step_nxt;
          state <= last_byte ? ST_DONE : ST_REQ;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_hold_inputs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(pc_q) && $stable(mode_q) && $stable(x_q) && $stable(y_q)));

  assert_operand_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && step == 2'd1) |-> (rd_addr == $past(rd_addr, 2) + 16'd1));

  assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_phase && step == 2'd3) |->
      ((rd_addr[7:0] == $past(rd_addr[7:0], 2) + 8'd1) && (rd_addr[15:8] == 8'h00)));

endmodule

// File: rtl/ea_arith.sv
module ea_arith
  import ea_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [ADDR_W-1:0] base_pc,
  input  logic [WORD_W-1:0] idx_x,
  input  logic [WORD_W-1:0] idx_y,
  input  logic [WORD_W-1:0] op_lo,
  input  logic [WORD_W-1:0] op_hi,
  input  logic [WORD_W-1:0] ptr_lo,
  input  logic [WORD_W-1:0] ptr_hi,
  output logic [ADDR_W-1:0] ea,
  output logic [ADDR_W-1:0] pc_next
);

  logic [ADDR_W-1:0] opnd16;
  logic [ADDR_W-1:0] ptr16;
  logic [ADDR_W-1:0] pc_plus1;

  always_comb begin
    opnd16   = {op_hi, op_lo};
    ptr16    = {ptr_hi, ptr_lo};
    pc_plus1 = base_pc + 16'd1;
    pc_next  = base_pc + {14'd0, operand_len(mode)};
    case (mode)
      AM_XIND: ea = ptr16;
      AM_ZP:   ea = page0(op_lo, 8'd0);
      AM_ABS:  ea = opnd16;
      AM_INDY: ea = index16(ptr16, idx_y);
      AM_ZPX:  ea = page0(op_lo, idx_x);
      AM_ABSY: ea = index16(opnd16, idx_y);
      AM_ABSX: ea = index16(opnd16, idx_x);
      AM_ZPY:  ea = page0(op_lo, idx_y);
      AM_REL:  ea = rel_target(pc_plus1, op_lo);
      default: ea = base_pc;
    endcase
  end

endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [WORD_W-1:0] x_in,
  input  logic [WORD_W-1:0] y_in,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] ea,
  output logic [ADDR_W-1:0] pc_next,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_data
);

  logic [MODE_W-1:0] mode_q;
  logic [ADDR_W-1:0] pc_q;
  logic [WORD_W-1:0] x_q, y_q, op_lo, op_hi, ptr_lo, ptr_hi;

  ea_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mode    (mode),
    .pc_in   (pc_in),
    .x_in    (x_in),
    .y_in    (y_in),
    .rd_data (rd_data),
    .busy    (busy),
    .done    (done),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .mode_q  (mode_q),
    .pc_q    (pc_q),
    .x_q     (x_q),
    .y_q     (y_q),
    .op_lo   (op_lo),
    .op_hi   (op_hi),
    .ptr_lo  (ptr_lo),
    .ptr_hi  (ptr_hi)
  );

  ea_arith u_arith (
    .mode    (mode_q),
    .base_pc (pc_q),
    .idx_x   (x_q),
    .idx_y   (y_q),
    .op_lo   (op_lo),
    .op_hi   (op_hi),
    .ptr_lo  (ptr_lo),
    .ptr_hi  (ptr_hi),
    .ea      (ea),
    .pc_next (pc_next)
  );

  assert_imm_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !reads_memory(mode)) |=> (done && !rd_en));

  assert_zp_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (mode_q == AM_ZP || mode_q == AM_ZPX || mode_q == AM_ZPY)) |-> (ea[15:8] == 8'h00));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> !rd_en);

endmodule

// File: tb/tb_ea_gen.sv
module tb_ea_gen;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] pc_in = '0;
  logic [7:0]  x_in = '0, y_in = '0;
  logic        busy, done, rd_en;
  logic [15:0] ea, pc_next, rd_addr;
  logic [7:0]  rd_data = '0;

  int checks = 0;
  int errors = 0;
  int salt = 0;
  int rd_cnt = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pc_in(pc_in),
    .x_in(x_in), .y_in(y_in), .busy(busy), .done(done), .ea(ea),
    .pc_next(pc_next), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Memory contents: a fixed function of the address and the salt.
  function automatic int mb(input int a);
    int lo, hi;
    lo = a % 256;
    hi = (a / 256) % 256;
    return (((lo * 2) % 256 + lo / 128) ^ hi ^ salt) % 256;
  endfunction

  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= 8'(mb(int'(rd_addr)));
      rd_cnt = rd_cnt + 1;
    end
  end

  function automatic string tag(input int m);
    case (m)
      0: return "R5";
      1, 5, 8: return "R3";
      3, 6, 7: return "R4";
      4: return "R6";
      9: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic model(input int m, input int pc, input int x, input int y,
                       output int e, output int pn, output int nrd);
    int b0, b1, p, lo, hi, off;
    b0 = mb(pc);
    b1 = mb((pc + 1) % 65536);
    pn = (pc + 1) % 65536;
    nrd = 1;
    case (m)
      1: e = b0;
      5: e = (b0 + x) % 256;
      8: e = (b0 + y) % 256;
      3, 6, 7: begin
        nrd = 2;
        pn = (pc + 2) % 65536;
        e = b1 * 256 + b0;
        if (m == 7) e = (e + x) % 65536;
        if (m == 6) e = (e + y) % 65536;
      end
      0, 4: begin
        nrd = 3;
        p = (m == 0) ? (b0 + x) % 256 : b0;
        lo = mb(p);
        hi = mb((p + 1) % 256);
        e = hi * 256 + lo;
        if (m == 4) e = (e + y) % 65536;
      end
      9: begin
        off = (b0 >= 128) ? b0 - 256 : b0;
        e = (pc + 1 + off + 65536) % 65536;
      end
      default: begin
        nrd = 0;
        e = pc;
      end
    endcase
  endtask

  task automatic run(input int m, input int pc, input int x, input int y, input bit intrude);
    int e, pn, nrd, lat;
    model(m, pc, x, y, e, pn, nrd);
    @(negedge clk);
    start = 1'b1; mode = 4'(m); pc_in = 16'(pc); x_in = 8'(x); y_in = 8'(y);
    rd_cnt = 0;
    @(negedge clk);
    lat = 1;
    while (!done && lat < 20) begin
      start = intrude && (lat == 2);
      if (start) begin
        mode = 4'(m ^ 4'd3); pc_in = ~16'(pc); x_in = ~8'(x); y_in = ~8'(y);
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check(tag(m), "done seen", int'(done), 1);
    check(tag(m), "ea", int'(ea), e);
    check(tag(m), "pc_next", int'(pc_next), pn);
    check("R9", "latency", lat, 1 + 2 * nrd);
    check("R8", "read count", rd_cnt, nrd);
    if (intrude) check("R10", "ea with intruding start", int'(ea), e);
    @(negedge clk);
    check("R9", "done one cycle", int'(done), 0);
    check("R8", "idle no read", int'(rd_en || busy), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int pcs[5];
    int idx[4];
    pcs = '{16'h0000, 16'h00FE, 16'h1234, 16'hFFFE, 16'hFFFF};
    idx = '{8'h00, 8'h01, 8'h80, 8'hFF};
    repeat (3) @(negedge clk);
    check("R11", "busy in reset", int'(busy), 0);
    check("R11", "done in reset", int'(done), 0);
    check("R11", "rd_en in reset", int'(rd_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "idle after reset", int'(busy || done || rd_en), 0);

    // R1: sweep every mode code, including the reserved ones
    for (int s = 0; s < 2; s++) begin
      salt = (s == 0) ? 8'h00 : 8'h5A;
      for (int m = 0; m < 16; m++)
        for (int p = 0; p < 5; p++)
          for (int i = 0; i < 4; i++)
            run(m, pcs[p], idx[i], idx[3 - i], 1'b0);
    end

    // R3: page-zero index wraps (b = 0xFF, X = 1 -> 0x0000)
    salt = 8'hFF ^ 8'h06 ^ 8'h03;
    run(5, 16'h0303, 1, 0, 1'b0);
    check("R3", "wrap to zero", int'(ea), 0);
    // R5: pointer location 0xFF, high byte from 0x00
    salt = 8'hFE ^ 8'h06 ^ 8'h03;
    run(0, 16'h0303, 1, 0, 1'b0);
    // R6: pointer at 0xFF wraps to 0x00 for its high byte, Y carries into high byte
    salt = 8'hFF ^ 8'h06 ^ 8'h03;
    run(4, 16'h0303, 0, 8'hFF, 1'b0);
    // R7: negative and positive offsets
    salt = 8'h80 ^ 8'h00 ^ 8'h10;
    run(9, 16'h1000, 0, 0, 1'b0);
    salt = 8'h7F ^ 8'hFE ^ 8'hFF;
    run(9, 16'hFF7F, 0, 0, 1'b0);

    // R10: requests raised while busy are ignored
    salt = 8'h33;
    for (int m = 0; m < 10; m++)
      if (m != 2) run(m, 16'h4321, 8'h12, 8'hF0, 1'b1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule